// File: doc/BRIEF.md
# I2C Multi-Address Slave Detector

This block listens to an I2C bus as a slave and decides whether the device should join each transfer. After a START condition it captures the address byte, which is seven address bits followed by the read/write bit. It compares the address with four programmable device IDs, and it also recognises the general call address. When the address is accepted, the block pulls SDA low for the acknowledge bit. It also issues one start interrupt that names the kind of transfer: read request, write request or general call.

When an accepted transaction ends with a STOP condition, the block sets a stop flag. The flag holds until software clears it, so it can be used to confirm that a transaction completed. Status outputs report whether an address is currently accepted, which ID matched, and the transfer direction.

The SCL and SDA inputs must already be synchronised to the block clock. Moving data bytes after the acknowledge is handled elsewhere.

Top module: `i2c_addr_watch`

## Requirements
- R1: After reset, `sdaPullLow`, all three start interrupts, `irqStop`, `addrMatched` and `dirRead` are 0.
- R2: The block captures an address byte after a START, which is SDA falling while SCL is high. It takes eight bits, MSB first, each sampled on an SCL rising edge; bits [7:1] are the address and bit 0 is R/W. If the address equals any of the four IDs, `sdaPullLow` goes high at the SCL falling edge that ends bit 8 and goes low at the next SCL falling edge.
- R3: An accepted address with R/W=1 raises a one-cycle `irqRead` pulse. An accepted address with R/W=0 raises a one-cycle `irqWrite` pulse. The pulse comes at the same edge where the acknowledge starts. `dirRead` then holds the R/W value.
- R4: The byte 0x00 (address 0, R/W=0) is acknowledged and raises `irqGenCall`, not `irqWrite`.
- R5: If the address matches nothing, the block gives no acknowledge and no interrupt. It then ignores all bus activity until the next START.
- R6: A STOP (SDA rising while SCL is high) that ends an accepted transaction sets `irqStop`. The flag holds until `stopClr` is pulsed. A STOP that ends an unaccepted transaction leaves it unchanged.
- R7: A repeated START restarts address capture and discards any partly received byte.
- R8: While `slaveEn` is 0, the block gives no acknowledge, no start interrupt and no stop flag.
- R9: `matchIdx` gives the lowest-numbered ID that equals the address. `addrMatched` is high from the acknowledge until the next STOP or START.
- R10: At most one of the three start interrupts is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slaveEn | input | 1 | Enables address monitoring |
| devIdList | input | NUM_IDS*ADDR_W | Device IDs; ID i is at bits [i*ADDR_W +: ADDR_W] |
| sclIn | input | 1 | Synchronised SCL level |
| sdaIn | input | 1 | Synchronised SDA level |
| stopClr | input | 1 | Clears the stop flag |
| sdaPullLow | output | 1 | Drive SDA low (acknowledge) |
| irqRead | output | 1 | Read request pulse |
| irqWrite | output | 1 | Write request pulse |
| irqGenCall | output | 1 | General call pulse |
| irqStop | output | 1 | Sticky stop flag |
| addrMatched | output | 1 | Address accepted, transaction active |
| matchIdx | output | IDX_W | Index of the matching ID |
| dirRead | output | 1 | R/W bit of the accepted address |

## Verification
A wrong bit count or a bad shift shows up at the ports within one byte time. The acknowledge appears on the wrong clock, or a valid ID gets no acknowledge at all. A state machine that fails to leave its ignore state, or leaves it too early, shows up on the next address as a missing or unexpected start interrupt. An error in the stop flag shows up at the first STOP after an accepted or rejected address, and again at the following clear.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WAITF, ST_ACK, ST_BUSY, ST_SKIP
  } watchState_t;

  typedef struct packed {
    logic shiftEn;
    logic cntClr;
  } dpCtl_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic byteDone;
    logic hit;
    logic genCall;
    logic rwBit;
  } busEvt_t;
endpackage

// File: rtl/i2cw_dp.sv
module i2cw_dp
  import i2cw_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int NUM_IDS = 4,
  localparam int BYTE_W = ADDR_W + 1,
  localparam int CNT_W  = $clog2(BYTE_W + 1),
  localparam int IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  input  logic [NUM_IDS*ADDR_W-1:0] devIdList,
  input  dpCtl_t                    ctl,
  output busEvt_t                   evt,
  output logic [IDX_W-1:0]          hitIdx
);
  logic sclQ, sdaQ;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [NUM_IDS-1:0] idHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      shiftReg <= '0;
      bitCnt <= '0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (ctl.cntClr) bitCnt <= '0;
      else if (ctl.shiftEn) begin
        bitCnt <= bitCnt + 1'b1;
        shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
      end
    end
  end

  // one comparator per programmable ID
  for (genvar i = 0; i < NUM_IDS; i++) begin : g_cmp
    assign idHit[i] = (shiftReg[BYTE_W-1:1] == devIdList[i*ADDR_W +: ADDR_W]);
  end

  // lowest index wins
  always_comb begin
    hitIdx = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (idHit[i]) hitIdx = IDX_W'(i);
    end
  end

  always_comb begin
    evt.start    = sclQ && sclIn && sdaQ && !sdaIn;
    evt.stop     = sclQ && sclIn && !sdaQ && sdaIn;
    evt.sclRise  = !sclQ && sclIn;
    evt.sclFall  = sclQ && !sclIn;
    evt.byteDone = (bitCnt == CNT_W'(BYTE_W));
    evt.hit      = |idHit;
    evt.genCall  = (shiftReg == '0);
    evt.rwBit    = shiftReg[0];
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntClr |=> (bitCnt == '0));
endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter int NUM_IDS = 4,
  localparam int IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slaveEn,
  input  logic             stopClr,
  input  busEvt_t          evt,
  input  logic [IDX_W-1:0] hitIdx,
  output dpCtl_t           ctl,
  output logic             sdaPullLow,
  output logic             irqRead,
  output logic             irqWrite,
  output logic             irqGenCall,
  output logic             irqStop,
  output logic             addrMatched,
  output logic [IDX_W-1:0] matchIdx,
  output logic             dirRead
);
  watchState_t state;

  always_comb begin
    ctl.cntClr  = evt.start;
    ctl.shiftEn = (state == ST_ADDR) && evt.sclRise && !evt.byteDone;
  end

  assign sdaPullLow  = (state == ST_ACK);
  assign addrMatched = (state == ST_ACK) || (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      irqRead    <= 1'b0;
      irqWrite   <= 1'b0;
      irqGenCall <= 1'b0;
      irqStop    <= 1'b0;
      matchIdx   <= '0;
      dirRead    <= 1'b0;
    end else begin
      irqRead    <= 1'b0;
      irqWrite   <= 1'b0;
      irqGenCall <= 1'b0;
      if (slaveEn && evt.stop && (state == ST_ACK || state == ST_BUSY))
        irqStop <= 1'b1;
      else if (stopClr)
        irqStop <= 1'b0;

      if (!slaveEn) state <= ST_IDLE;
      else if (evt.start) state <= ST_ADDR;
      else if (evt.stop) state <= ST_IDLE;
      else begin
        case (state)
          ST_ADDR:  if (evt.byteDone) state <= ST_WAITF;
          ST_WAITF: if (evt.sclFall) begin
            if (evt.genCall) begin
              state      <= ST_ACK;
              irqGenCall <= 1'b1;
              dirRead    <= 1'b0;
              matchIdx   <= '0;
            end else if (evt.hit) begin
              state    <= ST_ACK;
              irqRead  <= evt.rwBit;
              irqWrite <= !evt.rwBit;
              dirRead  <= evt.rwBit;
              matchIdx <= hitIdx;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ACK:   if (evt.sclFall) state <= ST_BUSY;
          default:  state <= state;
        endcase
      end
    end
  end

  a_r10_one_irq: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqRead, irqWrite, irqGenCall}));
  a_r3_read_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqRead |=> !irqRead);
  a_r3_irq_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    (irqRead || irqWrite || irqGenCall) |-> sdaPullLow);
  a_r4_gc_is_write: assert property (@(posedge clk) disable iff (!rstN)
    irqGenCall |-> !dirRead);
  a_r2_ack_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> $past(evt.sclFall));
  a_r6_stop_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqStop && !stopClr) |=> irqStop);
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !slaveEn |=> (!sdaPullLow && !irqRead && !irqWrite && !irqGenCall));
endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch
  import i2cw_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int NUM_IDS = 4,
  localparam int IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      slaveEn,
  input  logic [NUM_IDS*ADDR_W-1:0] devIdList,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  input  logic                      stopClr,
  output logic                      sdaPullLow,
  output logic                      irqRead,
  output logic                      irqWrite,
  output logic                      irqGenCall,
  output logic                      irqStop,
  output logic                      addrMatched,
  output logic [IDX_W-1:0]          matchIdx,
  output logic                      dirRead
);
  dpCtl_t          ctl;
  busEvt_t         evt;
  logic [IDX_W-1:0] hitIdx;

  i2cw_dp #(.ADDR_W(ADDR_W), .NUM_IDS(NUM_IDS)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devIdList(devIdList), .ctl(ctl), .evt(evt), .hitIdx(hitIdx)
  );

  i2cw_ctrl #(.NUM_IDS(NUM_IDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .slaveEn(slaveEn), .stopClr(stopClr),
    .evt(evt), .hitIdx(hitIdx), .ctl(ctl), .sdaPullLow(sdaPullLow),
    .irqRead(irqRead), .irqWrite(irqWrite), .irqGenCall(irqGenCall),
    .irqStop(irqStop), .addrMatched(addrMatched), .matchIdx(matchIdx),
    .dirRead(dirRead)
  );
endmodule

// File: tb/i2c_addr_watch_tb.sv
module i2c_addr_watch_tb_top;
  localparam int Q = 4;
  localparam int K_READ = 1, K_WRITE = 2, K_GC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveEn = 1'b0;
  logic [27:0] devIdList;
  logic sclIn = 1'b1, sdaIn = 1'b1, stopClr = 1'b0;
  logic sdaPullLow, irqRead, irqWrite, irqGenCall, irqStop, addrMatched, dirRead;
  logic [1:0] matchIdx;

  int nChecks = 0, nFails = 0;
  int expQ[$];
  int seenAck;

  always #10 clk = ~clk;

  i2c_addr_watch dut_i (
    .clk(clk), .rstN(rstN), .slaveEn(slaveEn), .devIdList(devIdList),
    .sclIn(sclIn), .sdaIn(sdaIn), .stopClr(stopClr), .sdaPullLow(sdaPullLow),
    .irqRead(irqRead), .irqWrite(irqWrite), .irqGenCall(irqGenCall),
    .irqStop(irqStop), .addrMatched(addrMatched), .matchIdx(matchIdx),
    .dirRead(dirRead)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // monitor: each start interrupt must match the next expected item
  always @(negedge clk) begin
    if (rstN && (irqRead || irqWrite || irqGenCall)) begin
      int got;
      got = irqRead ? K_READ : (irqWrite ? K_WRITE : K_GC);
      if (expQ.size() == 0) check("R5/R8 unexpected start irq", got, 0);
      else check("R3/R4 irq kind", got, expQ.pop_front());
    end
  end

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaIn = 1'b1; waitQ(Q);
    sclIn = 1'b1; waitQ(Q);
    sdaIn = 1'b0; waitQ(Q);
    sclIn = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    sdaIn = 1'b0; waitQ(Q);
    sclIn = 1'b1; waitQ(Q);
    sdaIn = 1'b1; waitQ(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaIn = b;    waitQ(Q);
    sclIn = 1'b1; waitQ(Q);
    sclIn = 1'b0; waitQ(Q);
  endtask

  // ninth clock with SDA released; records the pull seen mid-high
  task automatic ackBit();
    sdaIn = 1'b1; waitQ(Q);
    sclIn = 1'b1; waitQ(Q / 2);
    seenAck = int'(sdaPullLow);
    waitQ(Q - Q / 2);
    sclIn = 1'b0; waitQ(Q);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
  endtask

  task automatic addrPhase(input logic [6:0] a, input logic rw, input int kind,
                           input int expAck, input string req);
    if (kind != 0) expQ.push_back(kind);
    sendByte({a, rw});
    check({req, " ack pull after bit 8"}, int'(sdaPullLow), expAck);
    ackBit();
    check({req, " ack seen in ninth clock"}, seenAck, expAck);
    check({req, " pull released after ninth fall"}, int'(sdaPullLow), 0);
    check({req, " irq delivered"}, expQ.size(), 0);
    check("R9 addrMatched", int'(addrMatched), expAck);
  endtask

  initial begin
    devIdList = {7'h34, 7'h56, 7'h34, 7'h12}; // ID3..ID0
    #(20 * 200000);
    check("watchdog expired", 1, 0);
    summary();
  end

  initial begin
    waitQ(3);
    check("R1 reset pull", int'(sdaPullLow), 0);
    check("R1 reset irqs", int'({irqRead, irqWrite, irqGenCall, irqStop}), 0);
    check("R1 reset status", int'({addrMatched, dirRead}), 0);
    rstN = 1'b1; slaveEn = 1'b1; waitQ(Q);

    // write to ID0
    busStart();
    addrPhase(7'h12, 1'b0, K_WRITE, 1, "R2 R3 write");
    check("R9 idx id0", int'(matchIdx), 0);
    check("R3 dirRead write", int'(dirRead), 0);
    sendByte(8'hA5); sendBit(1'b1);
    check("R6 no flag before stop", int'(irqStop), 0);
    busStop(); waitQ(2);
    check("R6 stop flag set", int'(irqStop), 1);
    check("R9 addrMatched drops at stop", int'(addrMatched), 0);
    waitQ(10);
    check("R6 stop flag sticky", int'(irqStop), 1);
    stopClr = 1'b1; waitQ(1); stopClr = 1'b0; waitQ(1);
    check("R6 stop flag cleared", int'(irqStop), 0);

    // read from ID2
    busStart();
    addrPhase(7'h56, 1'b1, K_READ, 1, "R3 read");
    check("R9 idx id2", int'(matchIdx), 2);
    check("R3 dirRead read", int'(dirRead), 1);
    busStop(); waitQ(2);
    stopClr = 1'b1; waitQ(1); stopClr = 1'b0; waitQ(1);

    // 0x34 matches ID1 and ID3: lowest wins
    busStart();
    addrPhase(7'h34, 1'b0, K_WRITE, 1, "R9 priority");
    check("R9 idx lowest", int'(matchIdx), 1);
    busStop(); waitQ(2);
    stopClr = 1'b1; waitQ(1); stopClr = 1'b0; waitQ(1);

    // general call
    busStart();
    addrPhase(7'h00, 1'b0, K_GC, 1, "R4 general call");
    busStop(); waitQ(2);
    check("R4 gc stop flag", int'(irqStop), 1);
    stopClr = 1'b1; waitQ(1); stopClr = 1'b0; waitQ(1);

    // unmatched, then a matching-looking byte without START is ignored
    busStart();
    addrPhase(7'h7F, 1'b0, 0, 0, "R5 no match");
    sendByte({7'h12, 1'b0});
    check("R5 ignored byte no pull", int'(sdaPullLow), 0);
    ackBit();
    check("R5 ignored byte no ack", seenAck, 0);
    busStop(); waitQ(2);
    check("R6 no flag after unmatched", int'(irqStop), 0);

    // repeated START in the middle of an address
    busStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStart();
    addrPhase(7'h56, 1'b1, K_READ, 1, "R7 repeated start");
    check("R7 idx after restart", int'(matchIdx), 2);
    busStop(); waitQ(2);
    stopClr = 1'b1; waitQ(1); stopClr = 1'b0; waitQ(1);

    // disabled
    slaveEn = 1'b0; waitQ(2);
    busStart();
    addrPhase(7'h12, 1'b0, 0, 0, "R8 disabled");
    busStop(); waitQ(2);
    check("R8 no stop flag", int'(irqStop), 0);

    waitQ(4);
    summary();
  end
endmodule